// File: doc/BRIEF.md
# Watchdog Timer with Guarded Two-Write Feed

This block is a 32-bit down-counting watchdog that sits on a simple register bus. Software picks a reload value, sets the enable bit, and then proves it is alive by a two-write feed on a dedicated feed register. The opening write carries 0xAA and the closing write carries 0x55. Each completed feed reloads the counter. If the counter runs down to zero, the block raises a sticky timeout flag. If reset generation has been allowed, it also emits a one-cycle reset pulse.

The feed is guarded. After the opening write, the next selected access to any watchdog register must be the closing write. Any other selected access, whether a read, a write elsewhere, a repeated opening byte or a wrong value, trips the watchdog at once if it is running. The two writes may be any distance apart, and bus cycles with the select low never disturb a pending feed. Setting the enable bit only arms the block. Counting starts with the first complete feed made while the enable bit is set. Until then, broken feed sequences are harmless, so the registers can be configured in any order.

Top module: `wdt_guard`

## Requirements
- R1: After reset, the mode register reads 0, the reload register reads 0xFFFFFFFF, the count register reads 0, and both `timeout_flag` and `wdt_reset` are low.
- R2: Register map on `bus_addr`: 0 is the mode register (bit 0 enable, bit 1 reset-enable, bit 2 timeout flag, which is read-only), 1 is the reload value, 2 is the feed register (reads 0), and 3 is the live count (read-only). `bus_rdata` shows the addressed register in the same cycle.
- R3: The enable and reset-enable bits only ever get set. Writing 0 to them leaves them at 1, and only the reset input clears them.
- R4: While the watchdog is not running, the count holds. Setting the enable bit alone does not start it, and a complete feed made while the enable bit is clear leaves the count at 0.
- R5: A complete feed made with the enable bit set loads the reload value into the count on the edge that takes the 0x55 write. The count then drops by one on every following edge.
- R6: When a running count is 0 on an edge, that edge sets the sticky timeout flag (visible on `timeout_flag` and in mode bit 2) and stops the watchdog. The count then stays at 0.
- R7: Each timeout produces exactly one cycle of `wdt_reset` high, and only when reset-enable is set.
- R8: Any number of cycles may separate the 0xAA and 0x55 writes. Bus cycles with `bus_sel` low have no effect on the pending feed or on any register.
- R9: While the watchdog is running and a feed is pending, any selected access other than the 0x55 feed write times the watchdog out on that same edge.
- R10: A second 0xAA feed write while a feed is pending counts as a violation under R9.
- R11: A feed write whose low byte is not 0xAA, made with no feed pending, is ignored. Only `bus_wdata[7:0]` is compared for feed codes.
- R12: Before the watchdog is running, violations are ignored. They only cancel the pending feed.
- R13: A complete feed made while the watchdog is running reloads the count and postpones expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access to the watchdog register space this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register, combinational |
| timeout_flag | output | 1 | Sticky timeout indication |
| wdt_reset | output | 1 | One-cycle reset request on timeout |

## Verification
Register writes and feed completion take effect on the edge that samples the access. A count loaded with N on edge E therefore reads N just after E and 0 just after E+N. The timeout flag and reset pulse appear just after E+N+1. A violation shows on both outputs just after the edge that sampled the offending access, and the pulse is gone one edge later. The bench drives inputs on falling edges and samples on falling edges. Before each sample it counts the rising edges spent in every bus task, so each check lands in exactly the cycle these latencies predict.

// File: rtl/wdt_pkg.sv
// Shared definitions for the guarded watchdog: register selects,
// mode bit positions and the two feed codes.
// Assumes a 2-bit word address inside the watchdog register space.
package wdt_pkg;
    localparam int REG_ADDR_W = 2;
    localparam int FEED_W     = 8;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_MODE   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_FEED   = 2'd2,
        REG_COUNT  = 2'd3
    } reg_sel_e;

    localparam int MODE_EN_BIT   = 0;
    localparam int MODE_RSEN_BIT = 1;
    localparam int MODE_FLAG_BIT = 2;

    localparam logic [FEED_W-1:0] FEED_OPEN  = 8'hAA;
    localparam logic [FEED_W-1:0] FEED_CLOSE = 8'h55;
endpackage

// File: rtl/wdt_regs.sv
// Register file of the watchdog: sticky mode bits, the reload value and
// the combinational read multiplexer.
// Assumes writes happen only when bus_sel and bus_we are both high.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  flag,
    input  logic [DATA_W-1:0]     count,
    output logic                  en,
    output logic                  rst_en,
    output logic [DATA_W-1:0]     reload_val,
    output logic [DATA_W-1:0]     rdata
);
    logic wr_mode;
    logic wr_reload;

    assign wr_mode   = sel && we && (addr == REG_MODE);
    assign wr_reload = sel && we && (addr == REG_RELOAD);

    // Purpose: hold the set-only mode bits and the reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en         <= 1'b0;
            rst_en     <= 1'b0;
            reload_val <= '1;
        end else begin
            if (wr_mode) begin
                en     <= en     | wdata[MODE_EN_BIT];
                rst_en <= rst_en | wdata[MODE_RSEN_BIT];
            end
            if (wr_reload) begin
                reload_val <= wdata;
            end
        end
    end

    // Purpose: present the addressed register on the read bus.
    always_comb begin
        rdata = '0;
        case (addr)
            REG_MODE: begin
                rdata[MODE_EN_BIT]   = en;
                rdata[MODE_RSEN_BIT] = rst_en;
                rdata[MODE_FLAG_BIT] = flag;
            end
            REG_RELOAD: rdata = reload_val;
            REG_COUNT:  rdata = count;
            default:    rdata = '0;
        endcase
    end

    assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> en);
    assert_resen_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_en |=> rst_en);
    assert_reload_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reload |=> reload_val == $past(wdata));
    assert_unselected_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(reload_val));
endmodule

// File: rtl/wdt_feed_seq.sv
// Feed sequence tracker. It remembers an opening feed write and judges
// the next selected access: either a valid close or a violation.
// Assumes sel marks every access to the watchdog register space.
module wdt_feed_seq
    import wdt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sel,
    input  logic                  we,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [FEED_W-1:0]     feed_byte,
    output logic                  feed_ok,
    output logic                  breach
);
    logic pending;
    logic feed_wr;
    logic opens;

    assign feed_wr = sel && we && (addr == REG_FEED);
    assign opens   = feed_wr && (feed_byte == FEED_OPEN);
    assign feed_ok = pending && feed_wr && (feed_byte == FEED_CLOSE);
    assign breach  = pending && sel && !feed_ok;

    // Purpose: track whether an opening feed write awaits its close.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (pending) begin
            if (sel) pending <= 1'b0;
        end else if (opens) begin
            pending <= 1'b1;
        end
    end

    assert_pending_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pending && sel |=> !pending);
    assert_open_arms_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pending && opens |=> pending);
    assert_gap_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pending && !sel |=> pending);
    assert_stray_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pending && !opens |=> !pending);
endmodule

// File: rtl/wdt_countdown.sv
// Countdown engine. It starts on a complete feed while enabled, counts
// down once per clock, and fires on expiry or on a feed violation.
// Assumes feed_ok and breach are never high together.
module wdt_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rst_en,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             feed_ok,
    input  logic             breach,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             wdt_reset
);
    logic active;
    logic fire;
    logic start;

    assign fire  = active && ((count == '0) || breach);
    assign start = feed_ok && en;

    // Purpose: run state, counter, sticky flag and reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            count     <= '0;
            flag      <= 1'b0;
            wdt_reset <= 1'b0;
        end else begin
            flag      <= flag | fire;
            wdt_reset <= fire && rst_en;
            if (fire) begin
                active <= 1'b0;
            end else if (start) begin
                active <= 1'b1;
                count  <= reload_val;
            end else if (active) begin
                count <= count - 1'b1;
            end
        end
    end

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> !wdt_reset);
    assert_pulse_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |-> rst_en);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);
    assert_decrement_R5: assert property (@(posedge clk) disable iff (!rst_n)
        active && (count != '0) && !breach && !feed_ok |=> count == $past(count) - 1'b1);
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !start |=> $stable(count));
    assert_breach_fires_R9: assert property (@(posedge clk) disable iff (!rst_n)
        active && breach |=> flag);
endmodule

// File: rtl/wdt_guard.sv
// Top of the guarded watchdog: ties the register file, feed tracker and
// countdown engine to the register bus.
// Assumes a single bus master and a synchronous active-low reset.
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  timeout_flag,
    output logic                  wdt_reset
);
    localparam int CNT_W = DATA_W;

    logic             en;
    logic             rst_en;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W-1:0] count;
    logic             feed_ok;
    logic             breach;

    wdt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (bus_sel),
        .we         (bus_we),
        .addr       (bus_addr),
        .wdata      (bus_wdata),
        .flag       (timeout_flag),
        .count      (count),
        .en         (en),
        .rst_en     (rst_en),
        .reload_val (reload_val),
        .rdata      (bus_rdata)
    );

    wdt_feed_seq u_feed (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (bus_sel),
        .we        (bus_we),
        .addr      (bus_addr),
        .feed_byte (bus_wdata[FEED_W-1:0]),
        .feed_ok   (feed_ok),
        .breach    (breach)
    );

    wdt_countdown #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .rst_en     (rst_en),
        .reload_val (reload_val),
        .feed_ok    (feed_ok),
        .breach     (breach),
        .count      (count),
        .flag       (timeout_flag),
        .wdt_reset  (wdt_reset)
    );
endmodule

// File: tb/wdt_guard_test.sv
// Directed bench for wdt_guard: one task per scenario, each self-checking.
module wdt_guard_test;
    import wdt_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        timeout_flag;
    logic        wdt_reset;

    int n_chk = 0;
    int n_fail = 0;

    wdt_guard uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timeout_flag(timeout_flag), .wdt_reset(wdt_reset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // All bus tasks start and end just after a falling edge.
    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic feed();
        bus_wr(REG_FEED, 32'hAA);
        bus_wr(REG_FEED, 32'h55);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        bus_rd(REG_MODE, v);   check("R1 mode", v, 32'd0);
        bus_rd(REG_RELOAD, v); check("R1 reload", v, 32'hFFFFFFFF);
        bus_rd(REG_COUNT, v);  check("R1 count", v, 32'd0);
        bus_rd(REG_FEED, v);   check("R2 feed reads zero", v, 32'd0);
        check("R1 outputs", {30'd0, timeout_flag, wdt_reset}, 32'd0);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        do_reset();
        bus_wr(REG_MODE, 32'h3);
        bus_wr(REG_MODE, 32'h0);
        bus_rd(REG_MODE, v); check("R3 sticky mode bits", v, 32'h3);
    endtask

    task automatic t_enable_no_start();
        logic [31:0] v;
        do_reset();
        bus_wr(REG_RELOAD, 32'd10);
        feed();
        bus_rd(REG_COUNT, v); check("R4 feed without enable", v, 32'd0);
        bus_wr(REG_MODE, 32'h1);
        idle(5);
        bus_rd(REG_COUNT, v); check("R4 enable alone holds", v, 32'd0);
        feed();
        bus_rd(REG_COUNT, v); check("R5 feed loads reload", v, 32'd10);
    endtask

    task automatic t_countdown_expire();
        logic [31:0] v;
        do_reset();
        bus_wr(REG_RELOAD, 32'd20);
        bus_wr(REG_MODE, 32'h3);
        feed();
        bus_rd(REG_COUNT, v); check("R5 count after feed", v, 32'd20);
        bus_rd(REG_COUNT, v); check("R5 count decrements", v, 32'd19);
        idle(18);
        check("R6 no flag at zero", {31'd0, timeout_flag}, 32'd0);
        idle(1);
        check("R6 flag on expiry", {31'd0, timeout_flag}, 32'd1);
        check("R7 reset pulse", {31'd0, wdt_reset}, 32'd1);
        idle(1);
        check("R7 pulse one cycle", {31'd0, wdt_reset}, 32'd0);
        bus_rd(REG_COUNT, v); check("R6 count stays zero", v, 32'd0);
        bus_rd(REG_MODE, v);  check("R6 mode flag bit", v, 32'h7);
    endtask

    task automatic t_no_reset_pulse();
        logic seen = 1'b0;
        do_reset();
        bus_wr(REG_RELOAD, 32'd3);
        bus_wr(REG_MODE, 32'h1);
        feed();
        for (int i = 0; i < 8; i++) begin
            idle(1);
            if (wdt_reset) seen = 1'b1;
        end
        check("R7 no pulse without reset-enable", {31'd0, seen}, 32'd0);
        check("R6 flag without reset-enable", {31'd0, timeout_flag}, 32'd1);
    endtask

    task automatic t_gap();
        logic [31:0] v;
        do_reset();
        bus_wr(REG_RELOAD, 32'd50);
        bus_wr(REG_MODE, 32'h1);
        feed();
        idle(5);
        bus_wr(REG_FEED, 32'hAA);
        bus_we = 1'b1; bus_addr = REG_RELOAD; bus_wdata = 32'd7;
        idle(10);
        bus_we = 1'b0;
        bus_wr(REG_FEED, 32'h55);
        bus_rd(REG_COUNT, v); check("R8 late close reloads", v, 32'd50);
        check("R8 gap no timeout", {31'd0, timeout_flag}, 32'd0);
    endtask

    task automatic t_violation();
        logic [31:0] v;
        logic [31:0] c1;
        do_reset();
        bus_wr(REG_RELOAD, 32'd100);
        bus_wr(REG_MODE, 32'h3);
        feed();
        bus_wr(REG_FEED, 32'hAA);
        bus_rd(REG_MODE, v);
        check("R9 flag on violating read", {31'd0, timeout_flag}, 32'd1);
        check("R9 pulse on violating read", {31'd0, wdt_reset}, 32'd1);
        bus_rd(REG_COUNT, c1);
        bus_rd(REG_COUNT, v); check("R9 counter stopped", v, c1);
    endtask

    task automatic t_double_open();
        do_reset();
        bus_wr(REG_RELOAD, 32'd100);
        bus_wr(REG_MODE, 32'h1);
        feed();
        bus_wr(REG_FEED, 32'hAA);
        bus_wr(REG_FEED, 32'hAA);
        check("R10 second open trips", {31'd0, timeout_flag}, 32'd1);
    endtask

    task automatic t_stray_feed();
        logic [31:0] v;
        do_reset();
        bus_wr(REG_RELOAD, 32'd100);
        bus_wr(REG_MODE, 32'h1);
        feed();
        idle(10);
        bus_wr(REG_FEED, 32'h55);
        bus_wr(REG_FEED, 32'h12);
        bus_wr(REG_RELOAD, 32'd100);
        bus_rd(REG_COUNT, v); check("R11 stray feed no reload", v, 32'd87);
        check("R11 stray feed no timeout", {31'd0, timeout_flag}, 32'd0);
    endtask

    task automatic t_prestart();
        logic [31:0] v;
        do_reset();
        bus_wr(REG_RELOAD, 32'd10);
        bus_wr(REG_MODE, 32'h1);
        bus_wr(REG_FEED, 32'hAA);
        bus_wr(REG_RELOAD, 32'd8);
        check("R12 violation ignored before start", {31'd0, timeout_flag}, 32'd0);
        feed();
        bus_rd(REG_COUNT, v); check("R12 start after ignored violation", v, 32'd8);
    endtask

    task automatic t_refeed();
        logic [31:0] v;
        do_reset();
        bus_wr(REG_RELOAD, 32'd10);
        bus_wr(REG_MODE, 32'h1);
        feed();
        idle(6);
        feed();
        bus_rd(REG_COUNT, v); check("R13 refeed reloads", v, 32'd10);
        idle(8);
        check("R13 expiry postponed", {31'd0, timeout_flag}, 32'd0);
        idle(2);
        check("R13 expiry after refeed", {31'd0, timeout_flag}, 32'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_sticky();
        t_enable_no_start();
        t_countdown_expire();
        t_no_reset_pulse();
        t_gap();
        t_violation();
        t_double_open();
        t_stray_feed();
        t_prestart();
        t_refeed();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule